// File: doc/BRIEF.md
# UART Interrupt Enable and Request Logic

This block holds the interrupt enable register of a UART and turns the receiver, transmitter, line and modem conditions into one interrupt request. The host writes four enable bits through a simple register port and can read them back at any time. Each enabled condition that is active is a pending source. The block raises a single request line while any source is pending and gives a level code that names the most urgent one.

The transmit-ready condition depends on the operating mode. Without FIFOs it is the holding-register-empty bit of the line status. With FIFOs enabled it also needs the transmit FIFO to be empty. The request output is combinational in the enables and conditions, so it follows a condition that sets or clears in the same cycle. The serial data path, the line status register and the modem status register are outside this block.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, all enable bits are 0. `ier_rdata` reads 0x00, and `irq` stays low and `irq_level` stays 0 whatever the conditions are.
- R2: A write with `ier_wr` high stores `ier_wdata[3:0]` at the next clock. `ier_rdata[3:0]` returns the stored bits and `ier_rdata[7:4]` always reads 0.
- R3: Enable bit 3 makes the modem source pending whenever any bit of `msr_delta[3:0]` is 1.
- R4: Enable bit 2 makes the line status source pending whenever any of `lsr_stat[4:1]` (the receive error bits) is 1.
- R5: Enable bit 1 with `fifo_mode` low makes the transmit-ready source pending whenever `lsr_stat[5]` (holding register empty) is 1.
- R6: Enable bit 1 with `fifo_mode` high makes the transmit-ready source pending only when both `lsr_stat[5]` and `tx_fifo_empty` are 1.
- R7: Enable bit 0 makes the receive-data source pending whenever `lsr_stat[0]` (data ready) is 1.
- R8: `irq_level` reports the highest-priority pending source. The codes are 1 for line status, 2 for receive data, 3 for transmit ready and 4 for modem status, and this list runs from highest to lowest priority. The code is 0 when no source is pending.
- R9: `irq` is 1 exactly while at least one source is pending, in the same cycle as the condition. A condition whose enable bit is 0 has no effect on `irq` or `irq_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read data |
| lsr_stat | input | 6 | Line status bits: 0 data ready, 1-4 receive errors, 5 holding register empty |
| msr_delta | input | 4 | Modem status change bits |
| fifo_mode | input | 1 | FIFOs enabled |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| irq | output | 1 | Interrupt request, active high |
| irq_level | output | 3 | Code of the highest pending source |

## Verification
On every cycle the assertions check the following. A write reads back one cycle later with the upper bits cleared. A zero level code goes together with a low request. The grant vector is at most one-hot. An enabled line error always wins, and a transmit-ready report always has its enable set. In FIFO mode a transmit-ready report also needs an empty FIFO. The full priority order can only be shown by the bench scenarios. They peel the sources away one at a time. They also show that masked conditions stay silent and that the two transmit modes give different results.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
   localparam int SRC_N = 4;
   // pending-vector index, index 0 is highest priority
   localparam int SRC_LINE  = 0;
   localparam int SRC_RX    = 1;
   localparam int SRC_TX    = 2;
   localparam int SRC_MODEM = 3;
   // enable register bit positions
   localparam int EN_RX    = 0;
   localparam int EN_TX    = 1;
   localparam int EN_LINE  = 2;
   localparam int EN_MODEM = 3;
   // line status bit positions
   localparam int LS_DR      = 0;
   localparam int LS_ERR_LO  = 1;
   localparam int LS_ERR_HI  = 4;
   localparam int LS_THRE    = 5;
   localparam int LVL_W = 3;
   typedef enum logic [LVL_W-1:0] {
      LVL_NONE   = 3'd0,
      LVL_LINE   = 3'd1,
      LVL_RXDATA = 3'd2,
      LVL_TXRDY  = 3'd3,
      LVL_MODEM  = 3'd4
   } irq_lvl_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
   parameter int DATA_W = 8,
   parameter int EN_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [EN_W-1:0]   en,
   output logic [DATA_W-1:0] rdata
);
   localparam int PAD_W = DATA_W - EN_W;

   if (EN_W < 1 || PAD_W < 0) begin : g_bad_width
      $error("irq_enable_reg: DATA_W must be at least EN_W");
   end

   logic [EN_W-1:0] en_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  en_q <= '0;
      else if (wr) en_q <= wdata[EN_W-1:0];
   end

   if (PAD_W > 0) begin : g_pad
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[DATA_W-1:EN_W];
      assign rdata = {{PAD_W{1'b0}}, en_q};
   end else begin : g_nopad
      assign rdata = en_q;
   end

   assign en = en_q;
endmodule

// File: rtl/irq_source_qual.sv
module irq_source_qual
   import uart_irq_pkg::*;
#(
   parameter int LSR_W        = 6,
   parameter int MSR_W        = 4,
   parameter bit FIFO_SUPPORT = 1'b1
) (
   input  logic [SRC_N-1:0] en,
   input  logic [LSR_W-1:0] lsr,
   input  logic [MSR_W-1:0] msr_delta,
   input  logic             fifo_mode,
   input  logic             tx_fifo_empty,
   output logic [SRC_N-1:0] pend,
   output logic             any
);
   if (LSR_W < LS_THRE + 1) begin : g_bad_lsr
      $error("irq_source_qual: LSR_W too small for the holding-empty bit");
   end
   if (MSR_W < 1) begin : g_bad_msr
      $error("irq_source_qual: MSR_W must be positive");
   end

   logic tx_cond;
   if (FIFO_SUPPORT) begin : g_fifo
      assign tx_cond = lsr[LS_THRE] & (~fifo_mode | tx_fifo_empty);
   end else begin : g_nofifo
      logic unused_fifo;
      assign unused_fifo = fifo_mode ^ tx_fifo_empty;
      assign tx_cond = lsr[LS_THRE];
   end

   assign pend[SRC_LINE]  = en[EN_LINE]  & (|lsr[LS_ERR_HI:LS_ERR_LO]);
   assign pend[SRC_RX]    = en[EN_RX]    & lsr[LS_DR];
   assign pend[SRC_TX]    = en[EN_TX]    & tx_cond;
   assign pend[SRC_MODEM] = en[EN_MODEM] & (|msr_delta);
   assign any = |pend;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
   import uart_irq_pkg::*;
#(
   parameter int N = SRC_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     pend,
   output logic [N-1:0]     grant,
   output logic [LVL_W-1:0] level
);
   if (N + 1 > (1 << LVL_W)) begin : g_bad_n
      $error("irq_prio_enc: level code too narrow for N sources");
   end

   logic [N:0] blocked;
   assign blocked[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]     = pend[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | pend[i];
   end

   always_comb begin
      level = '0;
      for (int i = 0; i < N; i++) begin
         if (grant[i]) level = LVL_W'(i + 1);
      end
   end

   assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int LSR_W        = 6,
   parameter int MSR_W        = 4,
   parameter bit FIFO_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ier_wr,
   input  logic [DATA_W-1:0] ier_wdata,
   output logic [DATA_W-1:0] ier_rdata,
   input  logic [LSR_W-1:0]  lsr_stat,
   input  logic [MSR_W-1:0]  msr_delta,
   input  logic              fifo_mode,
   input  logic              tx_fifo_empty,
   output logic              irq,
   output logic [LVL_W-1:0]  irq_level
);
   logic [SRC_N-1:0] en, pend, grant;

   irq_enable_reg #(.DATA_W(DATA_W), .EN_W(SRC_N)) u_ier (
      .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
      .en(en), .rdata(ier_rdata));

   irq_source_qual #(.LSR_W(LSR_W), .MSR_W(MSR_W), .FIFO_SUPPORT(FIFO_SUPPORT)) u_qual (
      .en(en), .lsr(lsr_stat), .msr_delta(msr_delta), .fifo_mode(fifo_mode),
      .tx_fifo_empty(tx_fifo_empty), .pend(pend), .any(irq));

   irq_prio_enc #(.N(SRC_N)) u_prio (
      .clk(clk), .rst_n(rst_n), .pend(pend), .grant(grant), .level(irq_level));

   assert_wr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ier_wr |=> ier_rdata == DATA_W'($past(ier_wdata[SRC_N-1:0])));
   assert_none_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level == LVL_NONE) == !irq);
   assert_modem_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_rdata[EN_MODEM] && |msr_delta) |-> irq);
   assert_line_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_rdata[EN_LINE] && |lsr_stat[LS_ERR_HI:LS_ERR_LO]) |-> irq_level == LVL_LINE);
   assert_tx_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level == LVL_TXRDY) |-> (ier_rdata[EN_TX] && lsr_stat[LS_THRE]));
   assert_rx_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_level == LVL_RXDATA) |-> (ier_rdata[EN_RX] && lsr_stat[LS_DR]));
   if (FIFO_SUPPORT) begin : g_fifo_chk
      assert_fifo_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (fifo_mode && irq_level == LVL_TXRDY) |-> tx_fifo_empty);
   end
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ier_wr = 1'b0;
   logic [7:0] ier_wdata = '0;
   logic [7:0] ier_rdata;
   logic [5:0] lsr_stat = '0;
   logic [3:0] msr_delta = '0;
   logic       fifo_mode = 1'b0;
   logic       tx_fifo_empty = 1'b0;
   logic       irq;
   logic [2:0] irq_level;
   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   uart_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
      .ier_rdata(ier_rdata), .lsr_stat(lsr_stat), .msr_delta(msr_delta),
      .fifo_mode(fifo_mode), .tx_fifo_empty(tx_fifo_empty),
      .irq(irq), .irq_level(irq_level));

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FIFO-free report: FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic settle();
      #2;
   endtask

   task automatic write_ier(input logic [7:0] v);
      @(negedge clk); ier_wr = 1'b1; ier_wdata = v;
      @(negedge clk); ier_wr = 1'b0; ier_wdata = 8'h00;
   endtask

   task automatic drive(input logic [5:0] l, input logic [3:0] m);
      @(negedge clk); lsr_stat = l; msr_delta = m; settle();
   endtask

   task automatic t_reset();
      lsr_stat = 6'h3F; msr_delta = 4'hF; tx_fifo_empty = 1'b1;
      #5; settle();
      check("R1 rdata", ier_rdata, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'd0);
      check("R1 level", {5'd0, irq_level}, 8'd0);
      rst_n = 1'b1;
      drive(6'h00, 4'h0);
      tx_fifo_empty = 1'b0;
   endtask

   task automatic t_readback();
      write_ier(8'hFF); settle();
      check("R2 upper zero", ier_rdata, 8'h0F);
      write_ier(8'hA5); settle();
      check("R2 low bits", ier_rdata, 8'h05);
      write_ier(8'h00); settle();
      check("R2 clear", ier_rdata, 8'h00);
   endtask

   task automatic t_modem();
      write_ier(8'h08);
      drive(6'h00, 4'h4);
      check("R3 irq", {7'd0, irq}, 8'd1);
      check("R3 level", {5'd0, irq_level}, 8'd4);
      drive(6'h00, 4'h0);
      check("R9 same-cycle clear", {7'd0, irq}, 8'd0);
   endtask

   task automatic t_line();
      write_ier(8'h04);
      drive(6'h10, 4'h0);
      check("R4 bit4 level", {5'd0, irq_level}, 8'd1);
      drive(6'h02, 4'h0);
      check("R4 bit1 irq", {7'd0, irq}, 8'd1);
      drive(6'h21, 4'h0);
      check("R4 non-error bits", {7'd0, irq}, 8'd0);
   endtask

   task automatic t_tx();
      write_ier(8'h02);
      fifo_mode = 1'b0; tx_fifo_empty = 1'b0;
      drive(6'h20, 4'h0);
      check("R5 level", {5'd0, irq_level}, 8'd3);
      fifo_mode = 1'b1;
      drive(6'h20, 4'h0);
      check("R6 fifo not empty", {7'd0, irq}, 8'd0);
      tx_fifo_empty = 1'b1;
      drive(6'h20, 4'h0);
      check("R6 fifo empty", {5'd0, irq_level}, 8'd3);
      drive(6'h00, 4'h0);
      check("R6 thr full", {7'd0, irq}, 8'd0);
      fifo_mode = 1'b0; tx_fifo_empty = 1'b0;
   endtask

   task automatic t_rx();
      write_ier(8'h01);
      drive(6'h01, 4'h0);
      check("R7 level", {5'd0, irq_level}, 8'd2);
      drive(6'h00, 4'h0);
      check("R7 clear", {7'd0, irq}, 8'd0);
   endtask

   task automatic t_priority();
      write_ier(8'h0F);
      drive(6'h3F, 4'hF);
      check("R8 line first", {5'd0, irq_level}, 8'd1);
      drive(6'h21, 4'hF);
      check("R8 rx second", {5'd0, irq_level}, 8'd2);
      drive(6'h20, 4'hF);
      check("R8 tx third", {5'd0, irq_level}, 8'd3);
      drive(6'h00, 4'hF);
      check("R8 modem last", {5'd0, irq_level}, 8'd4);
      drive(6'h00, 4'h0);
      check("R8 none", {5'd0, irq_level}, 8'd0);
   endtask

   task automatic t_masked();
      write_ier(8'hF0);
      drive(6'h3F, 4'hF);
      check("R9 masked irq", {7'd0, irq}, 8'd0);
      check("R9 masked level", {5'd0, irq_level}, 8'd0);
      write_ier(8'h0B);
      drive(6'h1E, 4'h0);
      check("R9 line masked", {7'd0, irq}, 8'd0);
      drive(6'h00, 4'h0);
   endtask

   initial begin : watchdog
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired got=timeout exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_readback();
      t_modem();
      t_line();
      t_tx();
      t_rx();
      t_priority();
      t_masked();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule